// File: doc/BRIEF.md
# Video PLL Divider Chain

This block is the divider path that follows a video PLL. It is written as clock-enable strobes: one fast reference clock runs all of its logic, and each "clock" inside the chain is a one-cycle pulse on that clock. An input selector picks one of two PLL-output strobes, and an enable gate follows it. A programmable pre-divider comes next, then a fixed divide-by-2 post stage. An output selector then chooses the pre-divided strobe, the post-divided strobe, or a divide-by-3.5 strobe built from the pre-divided one. The selected strobe goes to a programmable final divider, and that divider's output feeds the video clock trees further downstream.

Software writes a complete configuration word through one write strobe. The word is held in a shadow register and becomes active only at a final-divider output boundary. If the active gate is closed, the word becomes active on the next cycle instead. Because every ratio change starts from cleared counters, no shortened or doubled pulse appears on the outputs. The strobes carry no data, so the block has no valid/ready handshake and no back-pressure. The source strobes are sampled as plain pulses, and both outputs are plain pulses.

Top module: `vpd_chain`

## Requirements
- R1: While reset is asserted and after it is released with no write, both outputs are 0. The reset configuration has the gate closed.
- R2: Configuration bit 0 selects the source: 0 takes src_stb_i[0] and 1 takes src_stb_i[1]. The other source has no effect.
- R3: Configuration bit 1 is the gate enable. While the active gate is 0, sel_stb_o and fin_stb_o stay 0.
- R4: Configuration bits [4:2] hold value P. The pre-divider passes one strobe out of every P+1 gated strobes, so P=4 divides by 5 and P=5 divides by 6.
- R5: The post stage passes every second pre-divider strobe. With P=4 and the post output selected, the total divide is 10.
- R6: Configuration bits [6:5] pick the output: 0 selects the pre-divider strobe and 1 selects the post strobe. Values 2 and 3 select divide-by-3.5, which passes pre-divider strobes 1 and 4 of every group of 7, counted from the last counter restart.
- R7: Configuration bits [10:7] hold value N. The final divider passes one selected strobe out of every N+1, so its ratio runs from 1 to 16.
- R8: A written word becomes active at the edge where the final divider fires, or on the next edge if the active gate is 0. All divider counters restart from zero at that edge, and a later write before activation replaces the pending word.
- R9: Both outputs are registered. Each output pulse appears one cycle after the source strobe that causes it.
- R10: fin_stb_o is high only in cycles where sel_stb_o is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_stb_i | input | 2 | PLL-output strobes, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 11 | Configuration word (fields as in R2 to R7) |
| sel_stb_o | output | 1 | Strobe after the output selector |
| fin_stb_o | output | 1 | Strobe after the final divider |

## Verification
A strobe on every cycle isolates the divider arithmetic, so the measured ratio has to match the programmed one exactly. A pseudo-random gap pattern shows that the counters advance only on gated strobes and never on idle cycles. Source 1 strobes every third cycle while source 0 strobes on every cycle, which shows which source the selector actually took. The bench also rewrites the configuration in the middle of a final-divider period and times the pulses around it, which separates activation at the boundary from immediate activation.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  localparam int NSRC  = 2;
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int PRE_W = 3;
  localparam int FIN_W = 4;
  localparam int FRAC_PHASES = 7;
  localparam int FRAC_HIT_A  = 0;
  localparam int FRAC_HIT_B  = 3;

  typedef enum logic [1:0] {
    OSEL_PRE  = 2'd0,
    OSEL_POST = 2'd1,
    OSEL_FRAC = 2'd2,
    OSEL_FRX  = 2'd3
  } osel_e;

  typedef struct packed {
    logic [FIN_W-1:0] fin_n;
    osel_e            osel;
    logic [PRE_W-1:0] pre_n;
    logic             gate_en;
    logic [SEL_W-1:0] in_sel;
  } vpd_cfg_t;

  localparam int CFG_W = $bits(vpd_cfg_t);

  localparam vpd_cfg_t CFG_RST = '{
    fin_n:   '0,
    osel:    OSEL_POST,
    pre_n:   PRE_W'(4),
    gate_en: 1'b0,
    in_sel:  '0
  };
endpackage

// File: rtl/vpd_cnt_div.sv
module vpd_cnt_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_stb,
  input  logic [W-1:0] lim,
  output logic         out_stb
);
  logic [W-1:0] cnt;

  // Pass the strobe on which the count reaches its limit.
  assign out_stb = in_stb && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (in_stb) cnt <= out_stb ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/vpd_frac35.sv
module vpd_frac35 #(
  parameter int PHASES = 7,
  parameter int HIT_A  = 0,
  parameter int HIT_B  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_stb,
  output logic out_stb
);
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);
  localparam logic [PH_W-1:0] PH_A    = PH_W'(HIT_A);
  localparam logic [PH_W-1:0] PH_B    = PH_W'(HIT_B);

  logic [PH_W-1:0] ph;

  // Two hits per cycle of PHASES strobes, spaced 3 and 4 apart.
  assign out_stb = in_stb && ((ph == PH_A) || (ph == PH_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ph <= '0;
    else if (clr)    ph <= '0;
    else if (in_stb) ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
  end
endmodule

// File: rtl/vpd_cfg_shadow.sv
module vpd_cfg_shadow
  import vpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  vpd_cfg_t wdata,
  input  logic     boundary,
  output vpd_cfg_t act,
  output logic     load
);
  logic     pend;
  vpd_cfg_t pend_cfg;

  // Swap only at an output boundary, or at once while nothing flows.
  assign load = pend && (boundary || !act.gate_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= CFG_RST;
      pend     <= 1'b0;
      pend_cfg <= CFG_RST;
    end else begin
      if (load) act <= pend_cfg;
      if (we) begin
        pend     <= 1'b1;
        pend_cfg <= wdata;
      end else if (load) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vpd_chain.sv
module vpd_chain
  import vpd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_stb_i,
  input  logic                cfg_we_i,
  input  logic [CFG_W-1:0]    cfg_wdata_i,
  output logic                sel_stb_o,
  output logic                fin_stb_o
);
  vpd_cfg_t         act_cfg;
  logic [CFG_W-1:0] act_word;
  logic             load;
  logic             src_g;
  logic             pre_p;
  logic             post_p;
  logic             frac_p;
  logic             mux_p;
  logic             fin_p;

  assign act_word = act_cfg;

  vpd_cfg_shadow u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we_i),
    .wdata    (vpd_cfg_t'(cfg_wdata_i)),
    .boundary (fin_p),
    .act      (act_cfg),
    .load     (load)
  );

  // Input selector followed by the enable gate.
  generate
    if (NSRC > 1) begin : g_multi_src
      assign src_g = act_cfg.gate_en && src_stb_i[act_cfg.in_sel];
    end else begin : g_one_src
      assign src_g = act_cfg.gate_en && src_stb_i[0];
    end
  endgenerate

  vpd_cnt_div #(.W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .in_stb  (src_g),
    .lim     (act_cfg.pre_n),
    .out_stb (pre_p)
  );

  vpd_cnt_div #(.W(1)) u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .in_stb  (pre_p),
    .lim     (1'b1),
    .out_stb (post_p)
  );

  vpd_frac35 #(
    .PHASES (FRAC_PHASES),
    .HIT_A  (FRAC_HIT_A),
    .HIT_B  (FRAC_HIT_B)
  ) u_frac (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .in_stb  (pre_p),
    .out_stb (frac_p)
  );

  always_comb begin
    case (act_cfg.osel)
      OSEL_PRE:  mux_p = pre_p;
      OSEL_POST: mux_p = post_p;
      default:   mux_p = frac_p;
    endcase
  end

  vpd_cnt_div #(.W(FIN_W)) u_fin (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .in_stb  (mux_p),
    .lim     (act_cfg.fin_n),
    .out_stb (fin_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_stb_o <= 1'b0;
      fin_stb_o <= 1'b0;
    end else begin
      sel_stb_o <= mux_p;
      fin_stb_o <= fin_p;
    end
  end
endmodule

// File: rtl/vpd_chain_chk.sv
module vpd_chain_chk
  import vpd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_stb_i,
  input logic             sel_stb_o,
  input logic             fin_stb_o,
  input logic [CFG_W-1:0] act_word
);
  localparam int GATE_BIT = SEL_W;

  // R10
  fin_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_stb_o |-> sel_stb_o);

  // R3
  gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_word[GATE_BIT] |=> !sel_stb_o);

  // R9
  reg_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb_o |-> $past(|src_stb_i));

  // R8
  cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_word) |-> (fin_stb_o || !$past(act_word[GATE_BIT])));
endmodule

bind vpd_chain vpd_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_stb_i (src_stb_i),
  .sel_stb_o (sel_stb_o),
  .fin_stb_o (fin_stb_o),
  .act_word  (act_word)
);

// File: tb/vpd_chain_test.sv
`timescale 1ns/1ps
module vpd_chain_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  src_stb_i = 2'b00;
  logic        cfg_we_i = 1'b0;
  logic [10:0] cfg_wdata_i = '0;
  logic        sel_stb_o;
  logic        fin_stb_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int src_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  vpd_chain uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_stb_i   (src_stb_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .sel_stb_o   (sel_stb_o),
    .fin_stb_o   (fin_stb_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [10:0] mk(int isel, int en, int pre, int osel, int fin);
    return {4'(fin), 2'(osel), 3'(pre), 1'(en), 1'(isel)};
  endfunction

  // Stimulus: source 0 per mode, source 1 every third cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_stb_i[0] = (src_mode == 0) ? 1'b1 : lfsr[0];
      src_stb_i[1] = (cyc % 3 == 0);
    end
  end

  // Behavioural reference model.
  int  m_cfg, m_pend_cfg, m_pend;
  int  pc, tog, ph, fc;
  bit  exp_sel, exp_fin;
  bit  win_on = 0;
  int  win_src, win_sel, win_fin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = mk(0, 0, 4, 1, 0); m_pend = 0; m_pend_cfg = m_cfg;
      pc = 0; tog = 0; ph = 0; fc = 0;
      exp_sel = 0; exp_fin = 0;
    end else begin
      int en, isel, pre, osel, fin;
      bit g, pre_p, post_p, frac_p, m, f;
      isel = m_cfg & 1; en = (m_cfg >> 1) & 1; pre = (m_cfg >> 2) & 7;
      osel = (m_cfg >> 5) & 3; fin = (m_cfg >> 7) & 15;
      g      = en && src_stb_i[isel];
      pre_p  = g && (pc == pre);
      post_p = pre_p && (tog == 1);
      frac_p = pre_p && (ph == 0 || ph == 3);
      m      = (osel == 0) ? pre_p : (osel == 1) ? post_p : frac_p;
      f      = m && (fc == fin);
      if (win_on) begin
        win_src += int'(g); win_sel += int'(m); win_fin += int'(f);
      end
      exp_sel = m; exp_fin = f;
      if (g)     pc = pre_p ? 0 : pc + 1;
      if (pre_p) begin tog ^= 1; ph = (ph == 6) ? 0 : ph + 1; end
      if (m)     fc = f ? 0 : fc + 1;
      if (m_pend != 0 && (f || en == 0)) begin
        m_cfg = m_pend_cfg; pc = 0; tog = 0; ph = 0; fc = 0; m_pend = 0;
      end
      if (cfg_we_i) begin m_pend = 1; m_pend_cfg = cfg_wdata_i; end
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sel_stb_o == exp_sel, "R9 sel_stb_o vs model (R6)", sel_stb_o, exp_sel);
      chk(fin_stb_o == exp_fin, "R8 fin_stb_o vs model (R7)", fin_stb_o, exp_fin);
    end
  end

  task automatic write_cfg(input logic [10:0] w);
    @(posedge clk); #1;
    cfg_we_i = 1'b1; cfg_wdata_i = w;
    @(posedge clk); #1;
    cfg_we_i = 1'b0;
  endtask

  // Measured ratio must match num/den within one output period.
  task automatic measure(input int num, input int den, input string req);
    int lhs, rhs, d;
    repeat (700) @(posedge clk);
    #1; win_src = 0; win_sel = 0; win_fin = 0; win_on = 1;
    repeat (3500) @(posedge clk);
    #1; win_on = 0;
    lhs = win_fin * num; rhs = win_src * den;
    d = (lhs > rhs) ? lhs - rhs : rhs - lhs;
    chk(win_fin > 0, req, win_fin, 1);
    chk(d <= num, req, lhs, rhs);
  endtask

  task automatic wait_fin(output int t);
    do @(negedge clk); while (!fin_stb_o);
    t = cyc;
  endtask

  initial begin
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    chk(sel_stb_o == 1'b0, "R1 sel in reset", sel_stb_o, 0);
    chk(fin_stb_o == 1'b0, "R1 fin in reset", fin_stb_o, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(sel_stb_o == 1'b0 && fin_stb_o == 1'b0, "R1 idle after reset", sel_stb_o, 0);

    // R7: final divider at 16.
    write_cfg(mk(0, 1, 0, 0, 15));
    measure(16, 1, "R7 final divide 16");

    // R8: rewrite mid-period; old ratio holds to the boundary.
    wait_fin(t0);
    write_cfg(mk(0, 1, 4, 0, 0));
    wait_fin(t1);
    wait_fin(t2);
    chk(t1 - t0 == 16, "R8 old period kept", t1 - t0, 16);
    chk(t2 - t1 == 5, "R8 new ratio from restart", t2 - t1, 5);

    // R4: pre-divider 5 and 6.
    measure(5, 1, "R4 pre divide 5");
    write_cfg(mk(0, 1, 5, 0, 0));
    measure(6, 1, "R4 pre divide 6");

    // R5: post stage, total 10.
    write_cfg(mk(0, 1, 4, 1, 0));
    measure(10, 1, "R5 total divide 10");

    // R6: divide-by-3.5 after pre 5, and code 3.
    write_cfg(mk(0, 1, 4, 2, 0));
    measure(35, 2, "R6 frac 17.5");
    write_cfg(mk(0, 1, 0, 3, 0));
    measure(7, 2, "R6 frac code 3");

    // R7 with irregular strobes: 6 * 2 * 3 = 36.
    src_mode = 1;
    write_cfg(mk(0, 1, 5, 1, 2));
    measure(36, 1, "R7 chained divide 36");

    // R2: source 1 only.
    src_mode = 0;
    write_cfg(mk(1, 1, 4, 0, 0));
    measure(5, 1, "R2 source 1 divide 5");
    chk(win_src * 3 <= 3501 && win_src * 3 >= 3498, "R2 source 1 counted", win_src, 1167);

    // R3: gate closed.
    write_cfg(mk(0, 0, 4, 1, 0));
    repeat (700) @(posedge clk);
    #1; win_src = 0; win_sel = 0; win_fin = 0; win_on = 1;
    repeat (500) @(posedge clk);
    #1; win_on = 0;
    chk(win_sel == 0, "R3 gate closed sel", win_sel, 0);
    chk(win_fin == 0, "R3 gate closed fin", win_fin, 0);

    // R10 spot check is covered by the model; finish.
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule